// File: doc/BRIEF.md
# Indirect VLAN Table Access Controller

This block holds a small VLAN table that software cannot address directly. It sits behind a byte-wide register bus and offers five registers: a command register, an index register and three data registers that together form one staging entry. To read an entry, software writes the read command and then the entry number to the index register. The entry is copied into the data registers and can then be read byte by byte. To write an entry, software fills the data registers, writes the write command and then the entry number. The staging entry is then committed to the table.

Each table entry is 22 bits wide. It holds a valid flag, a 5-bit port-membership mask, a 4-bit filter identifier and a 12-bit VLAN identifier. An entry whose valid flag is clear always reads back as all zeros. Writing zero data to an entry therefore removes it. The payload storage has no reset and is shaped so that a block RAM can hold it. Validity is kept in a separate flop vector that reset clears.

Top module: `vlan_table_ctrl`

## Requirements
- R1: After reset, the command register and all three data registers read 0x00, and every table entry reads back as all zeros.
- R2: Register map. Command is at 0x6E and holds 8 bits. Data byte 0x76 holds entry bits 21:16 in its bits 5:0; its bits 7:6 always read 0. Byte 0x77 holds entry bits 15:8 and byte 0x78 holds entry bits 7:0. Each bus read returns the addressed register as it stood before the clock edge, on `reg_rdata` one cycle after the address is presented. Every other address, including the index register at 0x6F, reads 0x00.
- R3: Writing an index k below 16 to 0x6F while the command register holds 0x04 stores the staging entry in table entry k.
- R4: Writing an index k below 16 to 0x6F while the command register holds 0x14 loads entry k into the data registers at the next clock edge. Entry bit 21 is the valid flag, bits 20:16 are the membership mask, bits 15:12 are the filter ID and bits 11:0 are the VLAN ID.
- R5: An entry last written with bit 21 clear reads back as all zeros, whatever its other bits held. An all-zero write therefore invalidates an entry.
- R6: An index write with a value from 16 to 255 changes neither the table nor the data registers.
- R7: An index write while the command register holds any value other than 0x04 or 0x14 changes neither the table nor the data registers.
- R8: The command register keeps its value across index writes, so one command serves any number of later index writes.
- R9: If a bus write to a data register falls on the same clock edge as a table load, the bus value wins for that byte. The other bytes take the loaded entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Registered read data for the address of the previous cycle |

## Verification
A register write takes effect at the clock edge that samples the strobe. A table read started by an index write reaches the data registers one edge later. A bus read shows on `reg_rdata` after the edge that follows the address. The bench therefore drives on the falling edge and samples just after the rising edge. After every index read it lets one extra rising edge pass before reading a data byte. The collision case deliberately places a data-byte write on exactly that edge. The checker ties an in-range read command to a load strobe in the next cycle, and ties out-of-range or unknown commands to its absence.

// File: rtl/vtab_pkg.sv
package vtab_pkg;

  localparam int unsigned BUS_W   = 8;
  localparam int unsigned MASK_W  = 5;
  localparam int unsigned FID_W   = 4;
  localparam int unsigned VID_W   = 12;
  localparam int unsigned ENTRY_W = 1 + MASK_W + FID_W + VID_W;
  localparam int unsigned PAY_W   = ENTRY_W - 1;
  localparam int unsigned NBYTES  = (ENTRY_W + BUS_W - 1) / BUS_W;

  // register addresses; data bytes count downward from the low byte
  localparam logic [BUS_W-1:0] ADR_CMD  = 8'h6E;
  localparam logic [BUS_W-1:0] ADR_IDX  = 8'h6F;
  localparam logic [BUS_W-1:0] ADR_DLOW = 8'h78;

  localparam logic [BUS_W-1:0] OP_READ  = 8'h14;
  localparam logic [BUS_W-1:0] OP_WRITE = 8'h04;

  typedef struct packed {
    logic              valid;
    logic [MASK_W-1:0] ports;
    logic [FID_W-1:0]  fid;
    logic [VID_W-1:0]  vid;
  } vtab_entry_t;

endpackage

// File: rtl/vtab_store.sv
module vtab_store
  import vtab_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned IDX_W = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_wr,
  input  logic             go_rd,
  input  logic [IDX_W-1:0] idx,
  input  vtab_entry_t      wr_entry,
  output logic             ld_pend,
  output vtab_entry_t      ld_entry
);

  // payload array: no reset, single port, registered read
  logic [PAY_W-1:0]     ram [N_ENTRIES];
  logic [PAY_W-1:0]     rd_q;
  logic [N_ENTRIES-1:0] vld;
  logic                 vld_q;

  always_ff @(posedge clk) begin
    if (go_wr) ram[idx] <= wr_entry[PAY_W-1:0];
    if (go_rd) rd_q <= ram[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld     <= '0;
      vld_q   <= 1'b0;
      ld_pend <= 1'b0;
    end else begin
      if (go_wr) vld[idx] <= wr_entry.valid;
      if (go_rd) vld_q <= vld[idx];
      ld_pend <= go_rd;
    end
  end

  // invalid entries are presented as all zeros
  assign ld_entry = vld_q ? vtab_entry_t'({1'b1, rd_q}) : '0;

endmodule

// File: rtl/vtab_regs.sv
module vtab_regs
  import vtab_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned IDX_W = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  input  logic             reg_wr,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic             ld_pend,
  input  vtab_entry_t      ld_entry,
  output logic [BUS_W-1:0] cmd_q,
  output vtab_entry_t      stage,
  output logic             go_wr,
  output logic             go_rd,
  output logic [IDX_W-1:0] idx
);

  localparam int unsigned WIDE_W = NBYTES * BUS_W;
  localparam logic [BUS_W:0] LIMIT = (BUS_W+1)'(N_ENTRIES);

  logic              idx_hit;
  logic              in_range;
  logic [WIDE_W-1:0] data_w;
  logic [WIDE_W-1:0] ld_wide;
  logic [BUS_W-1:0]  rd_mux;

  assign idx_hit  = reg_wr && (reg_addr == ADR_IDX);
  assign in_range = {1'b0, reg_wdata} < LIMIT;
  assign go_rd    = idx_hit && in_range && (cmd_q == OP_READ);
  assign go_wr    = idx_hit && in_range && (cmd_q == OP_WRITE);
  assign idx      = reg_wdata[IDX_W-1:0];

  assign ld_wide  = {{(WIDE_W-ENTRY_W){1'b0}}, ld_entry};
  assign stage    = vtab_entry_t'(data_w[ENTRY_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst)                               cmd_q <= '0;
    else if (reg_wr && reg_addr == ADR_CMD) cmd_q <= reg_wdata;
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_dbyte
    localparam logic [BUS_W-1:0] BADDR = ADR_DLOW - BUS_W'(b);
    localparam int unsigned      KEEP  =
      (ENTRY_W >= (b+1)*BUS_W) ? BUS_W : ENTRY_W - b*BUS_W;
    localparam logic [BUS_W-1:0] BMASK = BUS_W'((1 << KEEP) - 1);
    logic [BUS_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                q <= '0;
      else if (reg_wr && reg_addr == BADDR)   q <= reg_wdata & BMASK;
      else if (ld_pend)                       q <= ld_wide[b*BUS_W +: BUS_W];
    end
    assign data_w[b*BUS_W +: BUS_W] = q;
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADR_CMD) rd_mux = cmd_q;
    for (int b = 0; b < int'(NBYTES); b++) begin
      if (reg_addr == ADR_DLOW - BUS_W'(b)) rd_mux = data_w[b*BUS_W +: BUS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/vlan_table_ctrl.sv
module vlan_table_ctrl
  import vtab_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_wr,
  output logic [7:0] reg_rdata
);

  localparam int unsigned IDX_W = $clog2(N_ENTRIES);

  logic [BUS_W-1:0] cmd_q;
  vtab_entry_t      stage;
  vtab_entry_t      ld_entry;
  logic             ld_pend;
  logic             go_wr;
  logic             go_rd;
  logic [IDX_W-1:0] idx;

  vtab_regs #(.N_ENTRIES(N_ENTRIES)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .ld_pend   (ld_pend),
    .ld_entry  (ld_entry),
    .cmd_q     (cmd_q),
    .stage     (stage),
    .go_wr     (go_wr),
    .go_rd     (go_rd),
    .idx       (idx)
  );

  vtab_store #(.N_ENTRIES(N_ENTRIES)) u_store (
    .clk      (clk),
    .rst      (rst),
    .go_wr    (go_wr),
    .go_rd    (go_rd),
    .idx      (idx),
    .wr_entry (stage),
    .ld_pend  (ld_pend),
    .ld_entry (ld_entry)
  );

endmodule

// File: rtl/vtab_checker.sv
module vtab_checker
  import vtab_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       reg_wr,
  input logic [7:0] reg_rdata,
  input logic [7:0] cmd_q,
  input logic       ld_pend
);

  localparam logic [8:0] LIMIT = 9'(N_ENTRIES);

  logic idx_wr;
  logic mapped;
  assign idx_wr = reg_wr && (reg_addr == ADR_IDX);
  assign mapped = (reg_addr == ADR_CMD) || (reg_addr == ADR_DLOW) ||
                  (reg_addr == ADR_DLOW - 8'd1) || (reg_addr == ADR_DLOW - 8'd2);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cmd_q == 8'h00 && reg_rdata == 8'h00));

  a_r4_read_loads: assert property (@(posedge clk) disable iff (rst)
    (idx_wr && cmd_q == OP_READ && {1'b0, reg_wdata} < LIMIT) |=> ld_pend);

  a_r6_range_ignored: assert property (@(posedge clk) disable iff (rst)
    (idx_wr && {1'b0, reg_wdata} >= LIMIT) |=> !ld_pend);

  a_r7_bad_cmd: assert property (@(posedge clk) disable iff (rst)
    (idx_wr && cmd_q != OP_READ && cmd_q != OP_WRITE) |=> !ld_pend);

  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> (reg_rdata == 8'h00));

  a_r2_spare_bits: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADR_DLOW - 8'd2) |=> (reg_rdata[7:6] == 2'b00));

endmodule

bind vlan_table_ctrl vtab_checker #(.N_ENTRIES(N_ENTRIES)) u_vtab_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .cmd_q     (cmd_q),
  .ld_pend   (ld_pend)
);

// File: tb/test_vlan_table_ctrl.sv
module test_vlan_table_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_rdata;

  int total = 0;
  int bad = 0;
  logic [21:0] model [16];

  always #10 clk = ~clk;

  vlan_table_ctrl #(.N_ENTRIES(16)) i_vlan_table_ctrl (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b0;
    @(posedge clk);
    #1 d = reg_rdata;
  endtask

  task automatic stage_get(output logic [21:0] e);
    logic [7:0] b2, b1, b0;
    bus_rd(8'h76, b2); bus_rd(8'h77, b1); bus_rd(8'h78, b0);
    e = {b2[5:0], b1, b0};
  endtask

  task automatic stage_put(input logic [21:0] e);
    bus_wr(8'h76, {2'b00, e[21:16]});
    bus_wr(8'h77, e[15:8]);
    bus_wr(8'h78, e[7:0]);
  endtask

  // index write with the read command already set; one edge for the load
  task automatic fetch(input int k, output logic [21:0] e);
    bus_wr(8'h6F, 8'(k));
    @(posedge clk);
    stage_get(e);
  endtask

  function automatic logic [21:0] pat(input int k);
    return {1'b1, 5'(k*7+3), 4'(k ^ 5), 12'(k*291+17)};
  endfunction

  function automatic logic [21:0] seen(input logic [21:0] e);
    return e[21] ? e : 22'h0;
  endfunction

  task automatic check_table(input string req);
    logic [21:0] e;
    bus_wr(8'h6E, 8'h14);
    for (int k = 0; k < 16; k++) begin
      fetch(k, e);
      check(req, {10'h0, e}, {10'h0, seen(model[k])});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [7:0]  exp8;
    logic [21:0] e;
    for (int k = 0; k < 16; k++) model[k] = 22'h0;

    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state of registers and table
    bus_rd(8'h6E, b); check("R1 cmd", {24'h0, b}, 32'h0);
    stage_get(e);     check("R1 data", {10'h0, e}, 32'h0);
    check_table("R1 table");

    // R2: register map sweep with spare-bit masking
    bus_wr(8'h76, 8'hFF); bus_wr(8'h77, 8'h5A); bus_wr(8'h78, 8'hC3);
    bus_wr(8'h6E, 8'h33); bus_wr(8'h6F, 8'h02);
    for (int a = 0; a < 256; a++) begin
      case (a)
        8'h6E:   exp8 = 8'h33;
        8'h76:   exp8 = 8'h3F;
        8'h77:   exp8 = 8'h5A;
        8'h78:   exp8 = 8'hC3;
        default: exp8 = 8'h00;
      endcase
      bus_rd(8'(a), b);
      check("R2 map", {24'h0, b}, {24'h0, exp8});
    end

    // R3, R8: one write command, then 16 index writes
    bus_wr(8'h6E, 8'h04);
    for (int k = 0; k < 16; k++) begin
      stage_put(pat(k));
      bus_wr(8'h6F, 8'(k));
      model[k] = pat(k);
    end
    bus_rd(8'h6E, b); check("R8 cmd kept", {24'h0, b}, 32'h04);
    // R4: field-by-field read back
    check_table("R3 R4 readback");

    // R5: zero write invalidates, cleared valid bit hides payload
    bus_wr(8'h6E, 8'h04);
    for (int k = 0; k < 16; k += 2) begin
      stage_put(22'h0); bus_wr(8'h6F, 8'(k)); model[k] = 22'h0;
    end
    stage_put(22'h0F_ABC); bus_wr(8'h6F, 8'd1); model[1] = 22'h0F_ABC;
    check_table("R5 invalid");

    // R6: out-of-range indexes with both commands
    stage_put(22'h3F_FFFF);
    bus_wr(8'h6E, 8'h04);
    for (int k = 16; k < 256; k++) bus_wr(8'h6F, 8'(k));
    bus_wr(8'h6E, 8'h14);
    bus_wr(8'h6F, 8'd200);
    @(posedge clk);
    stage_get(e); check("R6 data kept", {10'h0, e}, 32'h3F_FFFF);
    check_table("R6 table");

    // R7: unknown command leaves table and data alone
    stage_put(22'h2A_5A5A);
    bus_wr(8'h6E, 8'h05); bus_wr(8'h6F, 8'd3);
    bus_wr(8'h6E, 8'h00); bus_wr(8'h6F, 8'd5);
    @(posedge clk);
    stage_get(e); check("R7 data kept", {10'h0, e}, 32'h2A_5A5A);
    check_table("R7 table");

    // R9: data write on the load edge wins for its byte
    bus_wr(8'h6E, 8'h14);
    bus_wr(8'h6F, 8'd7);
    bus_wr(8'h78, 8'hA5);
    stage_get(e);
    check("R9 collision", {10'h0, e}, {10'h0, pat(7)[21:8], 8'hA5});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule